// File: doc/BRIEF.md
# Batched Priority Memory Request Arbiter

This block merges four on-chip request streams into one off-chip memory request port. The four streams are graph edge reads, input feature reads, weight reads and output feature writes. Each stream offers an address over a valid/ready handshake. The arbiter forwards at most one request per cycle to memory, together with a tag that names the stream it came from.

Arbitration works in rounds. When the arbiter is idle and sees at least one pending stream, it records which streams are pending at that moment. It then serves only the recorded streams, in a fixed order: edge first, then input feature, then weight, then output feature. Each recorded stream is served back to back until its valid drops or it reaches a burst cap. Keeping one stream's requests together lets consecutive accesses tend to stay in the same open DRAM row.

A stream that becomes pending after the round was recorded waits for the next round. This bounds how long the low-ranked streams wait behind a busy high-ranked one.

Top module: `mem_req_arb`

## Requirements
- R1: While rst_ni is low, mem_valid_o and every bit of req_ready_o are low, whatever the request inputs do.
- R2: When no round is in progress and no stream is pending, mem_valid_o stays low and no round is recorded.
- R3: Within a round, a recorded stream with a lower index is always served before one with a higher index. The index is also the tag on mem_src_o: 0 edge, 1 input feature, 2 weight, 3 output feature.
- R4: mem_addr_o always carries the address that the tagged stream currently presents on its slice req_addr_i[s*ADDR_W +: ADDR_W].
- R5: A stream is served on consecutive transfers until its valid drops or MAX_BURST transfers (default 4) are taken. Only then does service move to the next recorded stream.
- R6: A stream that was not pending when the round was recorded is not granted in that round, even if it ranks higher.
- R7: While mem_valid_o is high and mem_ready_i is low, the next cycle shows the same valid, tag and address.
- R8: At most one bit of req_ready_o is high at a time. That bit belongs to the stream being served and is high only while mem_ready_i is high.
- R9: A round is recorded on the clock edge where an idle arbiter sees pending streams. The first grant of that round appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 4 | Per-stream request valid, bit s = stream s |
| req_addr_i | input | 4*ADDR_W | Per-stream addresses, stream s in bits [s*ADDR_W +: ADDR_W] |
| req_ready_o | output | 4 | Per-stream accept, one-hot or zero |
| mem_valid_o | output | 1 | Request valid toward memory |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | ADDR_W | Forwarded address |
| mem_src_o | output | 2 | Tag of the forwarded stream |

## Verification
The bench first tries a high-ranked stream that arrives just after a round has been recorded. An arbiter that re-ranks every cycle would issue it ahead of the pending output-feature requests.

It then keeps a stream pending beyond the burst cap. A missing or off-by-one cap would either let the edge stream keep the port or cut it off early, and the issued order would show this.

Random memory stalls check that a stalled grant keeps its tag and address and that only one stream is accepted. A design that moves the grant during a stall would drop or duplicate addresses against the reference queues.

A stream whose valid drops partway through the round must release service to the next recorded stream rather than hang the round.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_EDGE = 2'd0,
    SRC_FEAT = 2'd1,
    SRC_WGT  = 2'd2,
    SRC_OUTF = 2'd3
  } src_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask_i,
  output logic             any_o,
  output logic [N-1:0]     onehot_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  for (genvar i = 0; i < N; i++) begin : g_oh
    if (i == 0) begin : g_first
      assign onehot_o[i] = mask_i[i];
    end else begin : g_rest
      assign onehot_o[i] = mask_i[i] & ~(|mask_i[i-1:0]);
    end
  end

  assign any_o = |mask_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/arb_addr_mux.sv
module arb_addr_mux #(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N*ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]    sel_i,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [ADDR_W-1:0] lane [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign lane[i] = addr_i[i*ADDR_W +: ADDR_W];
  end

  assign addr_o = lane[sel_i];
endmodule

// File: rtl/arb_burst_ctr.sv
module arb_burst_ctr #(
  parameter int MAX_BURST = 4,
  parameter int CNT_W     = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(MAX_BURST - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mem_req_arb.sv
module mem_req_arb
  import arb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        req_valid_i,
  input  logic [NUM_SRC*ADDR_W-1:0] req_addr_i,
  output logic [NUM_SRC-1:0]        req_ready_o,
  output logic                      mem_valid_o,
  input  logic                      mem_ready_i,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [SRC_W-1:0]          mem_src_o
);
  logic [NUM_SRC-1:0] snap_q, snap_d;
  logic [NUM_SRC-1:0] cur_oh;
  logic [SRC_W-1:0]   cur_idx;
  logic               active, cur_valid, fire, burst_last, done;

  arb_prio_pick #(.N(NUM_SRC), .IDX_W(SRC_W)) u_pick (
    .mask_i   (snap_q),
    .any_o    (active),
    .onehot_o (cur_oh),
    .idx_o    (cur_idx)
  );

  arb_addr_mux #(.N(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(SRC_W)) u_mux (
    .addr_i (req_addr_i),
    .sel_i  (cur_idx),
    .addr_o (mem_addr_o)
  );

  assign cur_valid   = |(req_valid_i & cur_oh);
  assign mem_valid_o = active & cur_valid;
  assign mem_src_o   = cur_idx;
  assign fire        = mem_valid_o & mem_ready_i;
  assign req_ready_o = cur_oh & {NUM_SRC{active & mem_ready_i}};

  // stream retires on cap or when it runs dry
  assign done = (fire & burst_last) | (active & ~cur_valid);

  arb_burst_ctr #(.MAX_BURST(MAX_BURST)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (done),
    .inc_i  (fire & ~burst_last),
    .last_o (burst_last)
  );

  always_comb begin
    snap_d = snap_q;
    if (!active)   snap_d = req_valid_i;
    else if (done) snap_d = snap_q & ~cur_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else         snap_q <= snap_d;
  end
endmodule

// File: rtl/mem_req_arb_chk.sv
module mem_req_arb_chk #(
  parameter int N         = 4,
  parameter int SRC_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      req_ready_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [SRC_W-1:0]  mem_src_o,
  input logic [N-1:0]      snap_q
);
  logic [N-1:0]     lower_mask;
  logic [SRC_W-1:0] last_src_q;
  int unsigned      run_q;

  assign lower_mask = (N'(1) << mem_src_o) - N'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 0;
      last_src_q <= '0;
    end else if (snap_q == '0) begin
      run_q <= 0;
    end else if (mem_valid_o && mem_ready_i) begin
      last_src_q <= mem_src_o;
      run_q      <= (run_q != 0 && last_src_q == mem_src_o) ? run_q + 1 : 1;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_src_o) && $stable(mem_addr_o));

  // R8
  one_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  // R8
  ready_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_ready_o) |-> mem_ready_i);

  // R6
  in_round_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> snap_q[mem_src_o]);

  // R3
  rank_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (snap_q & lower_mask) == '0);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_q == '0) |-> !mem_valid_o);

  // R5
  burst_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= MAX_BURST);
endmodule

bind mem_req_arb mem_req_arb_chk #(
  .N(arb_pkg::NUM_SRC), .SRC_W(arb_pkg::SRC_W), .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_src_o   (mem_src_o),
  .snap_q      (snap_q)
);

// File: tb/mem_req_arb_bench.sv
`timescale 1ns/1ps
module mem_req_arb_bench;
  localparam int AW   = 32;
  localparam int NS   = 4;
  localparam int MAXB = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NS-1:0]   req_valid_i = '0;
  logic [NS*AW-1:0] req_addr_i = '0;
  logic [NS-1:0]   req_ready_o;
  logic            mem_valid_o;
  logic            mem_ready_i = 1'b0;
  logic [AW-1:0]   mem_addr_o;
  logic [1:0]      mem_src_o;

  mem_req_arb #(.ADDR_W(AW), .MAX_BURST(MAXB)) u_mem_req_arb (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_ready_o,
    .mem_valid_o, .mem_ready_i, .mem_addr_o, .mem_src_o
  );

  always #4 clk_i = ~clk_i;

  int vectors = 0;
  int fails   = 0;
  int q [NS][$];
  int log_q [$];
  bit m_snap [NS];
  int m_cnt = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int seq [NS] = '{0, 0, 0, 0};

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(int s, int n);
    for (int k = 0; k < n; k++) begin
      q[s].push_back((s << 16) | seq[s]);
      seq[s]++;
    end
  endtask

  task automatic step();
    int cur;
    bit exp_v, rdy, fire;
    logic [NS-1:0] vbits;
    @(negedge clk_i);
    for (int s = 0; s < NS; s++) begin
      vbits[s] = q[s].size() > 0;
      req_addr_i[s*AW +: AW] = vbits[s] ? AW'(q[s][0]) : '0;
    end
    req_valid_i = vbits;
    rdy = (ready_mode != 0) ? lfsr[0] : 1'b1;
    mem_ready_i = rdy;
    #1;
    cur = -1;
    for (int s = 0; s < NS; s++) if (m_snap[s] && cur < 0) cur = s;
    exp_v = (cur >= 0) && vbits[cur];
    // R2 R9: valid only inside a recorded round
    chk(mem_valid_o == exp_v, "R2/R9 valid", mem_valid_o, exp_v);
    if (exp_v) begin
      // R3 ranking, R6 late streams excluded
      chk(mem_src_o == 2'(cur), "R3/R6 src", mem_src_o, cur);
      // R4 address of tagged stream
      chk(mem_addr_o == AW'(q[cur][0]), "R4 addr", mem_addr_o, q[cur][0]);
    end
    // R8 single accept
    chk(req_ready_o == ((cur >= 0 && rdy) ? NS'(1 << cur) : '0), "R8 ready",
        req_ready_o, (cur >= 0 && rdy) ? (1 << cur) : 0);
    @(posedge clk_i);
    fire = exp_v && rdy;
    if (cur < 0) begin
      for (int s = 0; s < NS; s++) m_snap[s] = vbits[s];
    end else if (fire) begin
      void'(q[cur].pop_front());
      log_q.push_back(cur);
      m_cnt++;
      if (m_cnt == MAXB) begin m_snap[cur] = 0; m_cnt = 0; end
    end else if (!exp_v) begin
      m_snap[cur] = 0; m_cnt = 0;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic drain();
    int guard = 0;
    while ((q[0].size() + q[1].size() + q[2].size() + q[3].size()) > 0 && guard < 4000) begin
      step(); guard++;
    end
    if (guard >= 4000) chk(0, "R5 drain timeout", guard, 0);
    for (int k = 0; k < 3; k++) step();
  endtask

  task automatic check_log(int exp[$], string tag);
    chk(log_q.size() == exp.size(), tag, log_q.size(), exp.size());
    for (int k = 0; k < exp.size() && k < log_q.size(); k++)
      chk(log_q[k] == exp[k], tag, log_q[k], exp[k]);
    log_q.delete();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) m_snap[s] = 0;
    // R1: outputs quiet in reset despite requests
    req_valid_i = '1;
    mem_ready_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); #1;
      chk(mem_valid_o == 1'b0, "R1 valid", mem_valid_o, 0);
      chk(req_ready_o == '0, "R1 ready", req_ready_o, 0);
    end
    req_valid_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: nothing pending
    for (int k = 0; k < 5; k++) step();

    // R3: order across all four streams; R9 first cycle idle
    push(3, 2); push(1, 2); push(2, 2); push(0, 2);
    step();
    chk(log_q.size() == 0, "R9 first grant latency", log_q.size(), 0);
    drain();
    check_log('{0, 0, 1, 1, 2, 2, 3, 3}, "R3 order");

    // R5: burst cap on the edge stream
    push(0, 6); push(2, 1);
    drain();
    check_log('{0, 0, 0, 0, 2, 0, 0}, "R5 burst cap");

    // R6: late high-ranked arrival waits
    push(3, 3);
    step();
    push(0, 2);
    drain();
    check_log('{3, 3, 3, 0, 0}, "R6 late arrival");

    // R7: random stalls, grouped service across two rounds
    ready_mode = 1;
    push(0, 5); push(1, 5); push(2, 5); push(3, 5);
    drain();
    check_log('{0, 0, 0, 0, 1, 1, 1, 1, 2, 2, 2, 2, 3, 3, 3, 3, 0, 1, 2, 3}, "R7 stalled order");

    // R4: stream drops valid partway (short queues) under stalls
    push(1, 1); push(2, 3);
    drain();
    check_log('{1, 2, 2, 2}, "R4 early drop");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule